// File: doc/BRIEF.md
# Frequency Window Presence Detector

This block decides whether a one-bit square wave (a sine already squared by an external comparator or tuned amplifier) holds a frequency between a lower and an upper limit, 9 MHz and 10 MHz by default. It does not take multi-bit samples. It oversamples the single bit with a fast system clock and passes it through a short synchronizer chain of flip-flops. It then times the gap between successive rising edges with a counter.

A presence flag goes high only after an unbroken run of in-window periods, 20 by default. The flag stays high while the run continues. It falls at the first period that leaves the window, and also when edges stop arriving. A one-cycle strobe marks every edge that closes an in-window period. The flag therefore changes at most once per input period, far slower than the sampling rate. A microcontroller pin can follow it directly.

Top module: `freq_window_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `present_o` and `period_ok_o` are 0.
- R2: `sig_in` passes through SYNC_STAGES flip-flops (default 2) and a rising-edge detector. A rising edge of `sig_in` affects the outputs SYNC_STAGES+1 clocks later (3 by default). Each detected rising edge ends one period measurement and starts the next.
- R3: A period is in window when its length in clocks lies between MIN_PER = floor(CLK_HZ/F_HI_HZ) and MAX_PER = floor(CLK_HZ/F_LO_HZ), both limits included. At the defaults (200 MHz, 10 MHz, 9 MHz) these are 20 and 22 clocks. Elaboration rejects a clock below four times F_HI_HZ.
- R4: `period_ok_o` is a single-clock pulse. It is issued only for an edge that completes an in-window period.
- R5: The first rising edge after reset is not measured. It only starts timing and gives no strobe.
- R6: `present_o` rises on the edge that completes the RUN_LEN-th consecutive in-window period (default 20), and never earlier.
- R7: `present_o` stays 1 while every following period is in window.
- R8: A period outside the window clears the run and drops `present_o`. That same edge starts the next measurement, so the next period can count again.
- R9: If no edge arrives when MAX_PER+1 clocks have passed since the last one, the signal counts as lost. `present_o` drops, the run clears, and the next edge only restarts timing, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, nominal frequency CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Asynchronous squared input signal |
| present_o | output | 1 | High while a qualified in-window signal is present |
| period_ok_o | output | 1 | One-clock pulse per accepted period |

## Verification
On every cycle the bound checker confirms four things: the outputs are quiet after reset, the strobe never lasts two cycles, accepted strobes are never closer than the minimum period, and the flag only rises together with a strobe. It also tracks the raw input and confirms that a long still input always ends with the flag low. The exact window limits, the count of twenty consecutive periods, the handling of the arming edge, and the difference between a rejected period and signal loss depend on the history of edge gaps. Only the bench's scoreboard shows these, by predicting the strobe and flag for every input edge, including periods of 19, 23 and 24 clocks and long gaps.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Clocks per input period at a given frequency, truncated.
   function automatic int unsigned clocks_per_period(input int unsigned clk_hz,
                                                     input int unsigned sig_hz);
      return clk_hz / sig_hz;
   endfunction

   // Width able to hold values 0..max_val.
   function automatic int unsigned width_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/fwd_edge_sync.sv
module fwd_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_in,
   output logic rise_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '0;
            else     sync_q <= sig_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '0;
            else     sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/fwd_period_timer.sv
module fwd_period_timer #(
   parameter int unsigned MAX_PER = 22,
   parameter int unsigned CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise_i,
   output logic             measure_o,
   output logic [CNT_W-1:0] period_o,
   output logic             loss_o
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PER + 1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   assign measure_o = rise_i & armed_q;
   assign period_o  = cnt_q;
   assign loss_o    = armed_q & ~rise_i & (cnt_q == LIMIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (rise_i) begin
         armed_q <= 1'b1;
         cnt_q   <= CNT_W'(1);
      end else if (loss_o) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (armed_q && cnt_q != LIMIT) begin
         cnt_q   <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/fwd_run_qual.sv
module fwd_run_qual #(
   parameter int unsigned MIN_PER = 20,
   parameter int unsigned MAX_PER = 22,
   parameter int unsigned RUN_LEN = 20,
   parameter int unsigned CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             measure_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             loss_i,
   output logic             present_o,
   output logic             period_ok_o
);
   localparam int unsigned RUN_W = fwd_pkg::width_for(RUN_LEN);
   localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_LEN);

   logic             in_win;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nx;

   assign in_win = (period_i >= CNT_W'(MIN_PER)) && (period_i <= CNT_W'(MAX_PER));
   assign run_nx = (run_q == RUN_FULL) ? run_q : run_q + RUN_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q       <= '0;
         present_o   <= 1'b0;
         period_ok_o <= 1'b0;
      end else begin
         period_ok_o <= 1'b0;
         if (measure_i && in_win) begin
            run_q       <= run_nx;
            present_o   <= (run_nx == RUN_FULL);
            period_ok_o <= 1'b1;
         end else if (measure_i || loss_i) begin
            run_q     <= '0;
            present_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/freq_window_detect.sv
module freq_window_detect #(
   parameter int unsigned CLK_HZ      = 200_000_000,
   parameter int unsigned F_LO_HZ     = 9_000_000,
   parameter int unsigned F_HI_HZ     = 10_000_000,
   parameter int unsigned RUN_LEN     = 20,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_in,
   output logic present_o,
   output logic period_ok_o
);
   localparam int unsigned MIN_PER = fwd_pkg::clocks_per_period(CLK_HZ, F_HI_HZ);
   localparam int unsigned MAX_PER = fwd_pkg::clocks_per_period(CLK_HZ, F_LO_HZ);
   localparam int unsigned CNT_W   = fwd_pkg::width_for(MAX_PER + 1);

   // R3: parameter sanity at elaboration
   generate
      if (CLK_HZ / 4 < F_HI_HZ) begin : g_bad_clk
         $error("clock must be at least four times the upper frequency");
      end
      if (F_LO_HZ >= F_HI_HZ) begin : g_bad_band
         $error("lower frequency must be below upper frequency");
      end
      if (RUN_LEN < 1 || SYNC_STAGES < 1) begin : g_bad_counts
         $error("run length and synchronizer depth must be at least one");
      end
   endgenerate

   logic             rise;
   logic             measure;
   logic             loss;
   logic [CNT_W-1:0] period;

   fwd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .sig_in (sig_in),
      .rise_o (rise)
   );

   fwd_period_timer #(.MAX_PER(MAX_PER), .CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .rise_i    (rise),
      .measure_o (measure),
      .period_o  (period),
      .loss_o    (loss)
   );

   fwd_run_qual #(
      .MIN_PER (MIN_PER),
      .MAX_PER (MAX_PER),
      .RUN_LEN (RUN_LEN),
      .CNT_W   (CNT_W)
   ) u_qual (
      .clk         (clk),
      .rst         (rst),
      .measure_i   (measure),
      .period_i    (period),
      .loss_i      (loss),
      .present_o   (present_o),
      .period_ok_o (period_ok_o)
   );
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
   parameter int unsigned MIN_PER     = 20,
   parameter int unsigned MAX_PER     = 22,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst,
   input logic sig_in,
   input logic present_o,
   input logic period_ok_o
);
   localparam int unsigned QUIET_LIM = MAX_PER + SYNC_STAGES + 6;

   logic [15:0] gap_q;
   logic        seen_q;
   logic [15:0] quiet_q;
   logic        raw_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q   <= '0;
         seen_q  <= 1'b0;
         quiet_q <= '0;
         raw_q   <= 1'b0;
      end else begin
         raw_q <= sig_in;
         if (period_ok_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
         end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
         end
         if (sig_in != raw_q)          quiet_q <= '0;
         else if (quiet_q != 16'hFFFF) quiet_q <= quiet_q + 16'd1;
      end
   end

   // R1
   p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!present_o && !period_ok_o));
   // R4
   p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
      period_ok_o |=> !period_ok_o);
   // R3
   p_strobe_spacing_r3: assert property (@(posedge clk) disable iff (rst)
      (period_ok_o && seen_q) |-> (gap_q >= 16'(MIN_PER - 1)));
   // R6
   p_rise_with_strobe_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(present_o) |-> period_ok_o);
   // R9
   p_quiet_input_drop_r9: assert property (@(posedge clk) disable iff (rst)
      (quiet_q >= 16'(QUIET_LIM)) |-> !present_o);
endmodule

bind freq_window_detect fwd_checker #(
   .MIN_PER     (MIN_PER),
   .MAX_PER     (MAX_PER),
   .SYNC_STAGES (SYNC_STAGES)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .sig_in      (sig_in),
   .present_o   (present_o),
   .period_ok_o (period_ok_o)
);

// File: tb/freq_window_detect_tb.sv
`timescale 1ns/1ps
module freq_window_detect_tb_top;
   localparam int MIN_P = 20;
   localparam int MAX_P = 22;
   localparam int RUN   = 20;
   localparam int LAT   = 3;   // R2: two sync flops + registered output

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sig = 1'b0;
   logic present;
   logic pok;

   always #2 clk = ~clk;   // 250 MHz

   freq_window_detect dut_i (
      .clk         (clk),
      .rst         (rst),
      .sig_in      (sig),
      .present_o   (present),
      .period_ok_o (pok)
   );

   typedef struct {
      logic  strobe;
      logic  pres;
      string req;
   } exp_t;

   exp_t   sb_q[$];
   int     checks = 0;
   int     fails  = 0;
   bit     done   = 1'b0;
   longint cyc    = 0;
   bit     m_armed = 1'b0;
   int     m_run   = 0;
   longint m_last  = 0;

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
   endtask

   // Model of one rising edge, from the requirements
   task automatic model_rise();
      exp_t   e;
      longint gap;
      gap = cyc - m_last;
      m_last = cyc;
      if (!m_armed) begin
         m_armed = 1'b1; m_run = 0;
         e = '{1'b0, 1'b0, "R5"};
      end else if (gap >= MAX_P + 2) begin
         m_run = 0;
         e = '{1'b0, 1'b0, "R9"};
      end else if (gap >= MIN_P && gap <= MAX_P) begin
         bit was;
         was = (m_run >= RUN);
         if (m_run < RUN) m_run++;
         e.strobe = 1'b1;
         e.pres   = (m_run >= RUN);
         e.req    = was ? "R7" : (e.pres ? "R6" : "R3");
      end else begin
         m_run = 0;
         e = '{1'b0, 1'b0, "R8"};
      end
      sb_q.push_back(e);
   endtask

   task automatic drive_period(input int p);
      sig = 1'b1;
      model_rise();
      repeat (p / 2) step();
      sig = 1'b0;
      repeat (p - p / 2) step();
   endtask

   // Long gap while present: holds, then loss (R7, R9)
   task automatic drive_long(input int p);
      sig = 1'b1;
      model_rise();
      repeat (4) step();
      sig = 1'b0;
      repeat (16) step();
      chk("R7", "present inside last window", present, 1'b1);
      repeat (10) step();
      chk("R9", "present after signal loss", present, 1'b0);
      repeat (p - 30) step();
   endtask

   // Monitor / scoreboard
   initial begin
      bit           prev = 1'b0;
      bit [LAT-1:0] pipe = '0;
      bit           want_low = 1'b0;
      forever begin
         @(negedge clk);
         #1;
         if (pipe[LAT-1]) begin
            if (sb_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R2 no expected item actual=%0b expected=none", pok);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(e.req, "strobe", pok, e.strobe);
               chk(e.req, "present", present, e.pres);
               want_low = e.strobe;
            end
         end else if (want_low) begin
            chk("R4", "strobe width", pok, 1'b0);
            want_low = 1'b0;
         end else if (pok === 1'b1) begin
            checks++; fails++;
            $display("FAIL R4 unexpected strobe actual=1 expected=0");
         end
         pipe = {pipe[LAT-2:0], sig && !prev};
         prev = sig;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned lcg;
      repeat (5) step();
      chk("R1", "present in reset", present, 1'b0);
      chk("R1", "strobe in reset", pok, 1'b0);
      rst = 1'b0;
      step();
      chk("R1", "present after reset", present, 1'b0);
      chk("R1", "strobe after reset", pok, 1'b0);

      repeat (RUN + 1) drive_period(21);       // arm + 20 good
      repeat (3) drive_period(MIN_P);
      repeat (3) drive_period(MAX_P);
      drive_long(40);                          // loss
      repeat (RUN + 1) drive_period(MAX_P);
      drive_period(MIN_P - 1);                 // reject, stays armed
      repeat (RUN) drive_period(MIN_P);
      drive_period(MAX_P + 1);                 // reject at one past window
      repeat (RUN) drive_period(21);
      drive_period(MAX_P + 2);                 // loss then re-arm
      repeat (RUN + 1) drive_period(21);

      lcg = 32'h1234_5678;
      for (int i = 0; i < 150; i++) begin
         lcg = lcg * 1103515245 + 12345;
         if (lcg[20:18] == 3'd0) drive_period(17 + int'(lcg[27:24] % 10));
         else                    drive_period(MIN_P + int'(lcg[27:24] % 3));
      end

      sig = 1'b0;
      repeat (40) step();
      checks++;
      if (sb_q.size() != 0) begin
         fails++;
         $display("FAIL R2 leftover items actual=%0d expected=0", sb_q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule